// File: doc/BRIEF.md
# CAN Bit Timing Synchronizer

This block produces the bit timing of a node on a CAN-style serial bus. A free-running prescaler turns the system clock into time quanta. A segment sequencer then walks each bit through four parts: a single sync quantum, a propagation stretch, phase segment 1 and phase segment 2. The receive line is sampled at the end of phase segment 1. The sampled level leaves the block with a one-cycle valid strobe. A second one-cycle strobe marks the transmit point at the end of phase segment 2.

The block re-aligns itself on recessive-to-dominant transitions. An edge counts only when the bit taken at the previous sample point was recessive and the current quantum is dominant.

- When the protocol layer raises the hard-sync enable, the edge quantum becomes the sync quantum of a new bit, whatever its phase error.
- Otherwise the phase error is clipped to the programmed jump width. A late error lengthens phase segment 1 of the current bit. An early error shortens phase segment 2.
- At most one adjustment of either kind is allowed between two sample points. This also filters short dominant spikes.

After reset the block sits idle on an assumed recessive bus. It waits for a dominant quantum while hard-sync is enabled. The sampled-bit output is a stream with no back-pressure: bus timing cannot stall, so there is no ready input, and the consumer must take every valid pulse.

Top module: `canbt_sync`

## Requirements
- R1: A time-quantum enable occurs on every (presc_i+1)-th clock edge counted from reset release. With no edges on the line, consecutive sample strobes are exactly 1+prop+ph1+ph2 quanta apart.
- R2: From reset until the first hard synchronization, samp_valid_o and txpt_o stay low, whatever rx_i does while hsync_en_i is low.
- R3: A quantum in which rx_i is 0 (dominant), the last sampled bit was 1 (recessive) and hsync_en_i is 1 becomes the sync quantum of a new bit. This holds in any segment and regardless of phase error. The next sample strobe comes prop+ph1 quanta later, and no transmit strobe is issued for the bit that was cut short.
- R4: An edge counts only as a 1-to-0 change relative to the last sampled bit. After a dominant sample, dominant quanta cause no adjustment.
- R5: An edge in quantum k (counted from 1) after the sync quantum, inside prop+ph1, delays the sample point by min(k, sjw) quanta.
- R6: An edge m quanta before the nominal end of phase segment 2 (m counted from 1) shortens the bit by d=min(m, sjw). If d equals m, the transmit strobe is issued in the edge quantum, which then serves as the sync quantum. Otherwise the transmit strobe comes d quanta early and a normal sync quantum follows.
- R7: At most one synchronization, hard or soft, happens between two sample points, even while the line stays dominant.
- R8: Any lengthening or shortening applies to one bit only; the following bit has nominal length.
- R9: A dominant spike starting at the first quantum of phase segment 1 and lasting prop+ph1 quanta is sampled as 1 when sjw is at least prop+1. When sjw is smaller, it is sampled as 0.
- R10: samp_valid_o and txpt_o are single-cycle pulses that never coincide. Each appears in the clock cycle after the enable edge of the quantum it closes. samp_bit_o holds rx_i as seen in the last quantum of phase segment 1.
- R11: An edge inside the sync quantum has zero phase error and leaves the bit length nominal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| presc_i | input | PRESC_W | Quantum length minus one, in clocks |
| prop_len_i | input | SEG_W | Propagation stretch length in quanta (at least 1) |
| ph1_len_i | input | SEG_W | Phase segment 1 length in quanta (at least 1) |
| ph2_len_i | input | SEG_W | Phase segment 2 length in quanta (at least 1) |
| sjw_i | input | SJW_W | Jump width in quanta, not above either phase segment |
| hsync_en_i | input | 1 | Allows hard synchronization on the next qualifying edge |
| rx_i | input | 1 | Receive line, 1 = recessive, 0 = dominant, already synchronized |
| samp_valid_o | output | 1 | One-cycle strobe: sampled bit is valid |
| samp_bit_o | output | 1 | Sampled bus level |
| txpt_o | output | 1 | One-cycle transmit-point strobe |

## Verification
The assertions take for granted that the timing configuration is legal while the block runs: every segment is at least one quantum, and the jump width fits in both phase segments. They also assume that the configuration changes only under reset, so the prescaler period and the clipping limits stay fixed between sample points. The bench changes configuration only while reset is held, and sweeps only jump widths up to the smaller phase segment. It drives rx_i and hsync_en_i once per quantum, aligned to the enable it can predict from reset release.

// File: rtl/canbt_pkg.sv
package canbt_pkg;
  typedef enum logic [1:0] {
    SEG_IDLE = 2'd0,
    SEG_SYNC = 2'd1,
    SEG_TS1  = 2'd2,
    SEG_PH2  = 2'd3
  } seg_e;
endpackage

// File: rtl/canbt_tq_div.sv
module canbt_tq_div #(
  parameter int PRESC_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [PRESC_W-1:0] presc_i,
  output logic               tq_o
);
  logic [PRESC_W-1:0] cnt;

  assign tq_o = (cnt == presc_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (tq_o) cnt <= '0;
    else           cnt <= cnt + PRESC_W'(1);
  end

  // R1
  tq_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tq_o && presc_i != '0 && $stable(presc_i)) |=> !tq_o);
endmodule

// File: rtl/canbt_edge_det.sv
module canbt_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic tq_i,
  input  logic rx_i,
  input  logic samp_i,
  input  logic sync_i,
  output logic edge_o
);
  logic prev_rec;
  logic synced;

  assign edge_o = tq_i & prev_rec & ~rx_i & ~synced;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_rec <= 1'b1;
      synced   <= 1'b0;
    end else if (samp_i) begin
      prev_rec <= rx_i;
      synced   <= 1'b0;
    end else if (sync_i) begin
      synced   <= 1'b1;
    end
  end

  // R7
  one_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_i |-> !synced);
  // R4
  edge_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_i |-> (prev_rec && !rx_i));
endmodule

// File: rtl/canbt_seg_fsm.sv
module canbt_seg_fsm
  import canbt_pkg::*;
#(
  parameter int SEG_W = 4,
  parameter int SJW_W = 3,
  localparam int CNT_W = SEG_W + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tq_i,
  input  logic             edge_i,
  input  logic             hsync_en_i,
  input  logic             rx_i,
  input  logic [CNT_W-1:0] t1_i,
  input  logic [CNT_W-1:0] t2_i,
  input  logic [SJW_W-1:0] sjw_i,
  output logic             samp_now_o,
  output logic             sync_now_o,
  output logic             samp_stb_o,
  output logic             samp_bit_o,
  output logic             txpt_o
);
  seg_e             seg;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] ext;
  logic [CNT_W-1:0] shr;

  logic             hard, resync;
  logic [CNT_W-1:0] sjw_x, late_err, early_err, late_adj, early_adj;
  logic [CNT_W-1:0] ext_n, shr_n;
  logic             full_early, ts1_end, ph2_end;

  always_comb begin
    sjw_x      = CNT_W'(sjw_i);
    hard       = edge_i & hsync_en_i;
    resync     = edge_i & ~hsync_en_i & (seg != SEG_IDLE);
    late_err   = cnt + CNT_W'(1);
    early_err  = t2_i - cnt;
    late_adj   = (late_err < sjw_x) ? late_err : sjw_x;
    early_adj  = (early_err < sjw_x) ? early_err : sjw_x;
    ext_n      = (seg == SEG_TS1 && resync) ? late_adj : ext;
    shr_n      = (seg == SEG_PH2 && resync) ? early_adj : shr;
    full_early = (seg == SEG_PH2) && resync && (early_adj == early_err);
    ts1_end    = (seg == SEG_TS1) && (cnt == t1_i + ext_n - CNT_W'(1));
    ph2_end    = (seg == SEG_PH2) && (cnt == t2_i - shr_n - CNT_W'(1));
  end

  assign samp_now_o = tq_i & ~hard & ts1_end;
  assign sync_now_o = tq_i & (hard | resync);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seg        <= SEG_IDLE;
      cnt        <= '0;
      ext        <= '0;
      shr        <= '0;
      samp_stb_o <= 1'b0;
      samp_bit_o <= 1'b1;
      txpt_o     <= 1'b0;
    end else begin
      samp_stb_o <= 1'b0;
      txpt_o     <= 1'b0;
      if (tq_i) begin
        if (hard) begin
          seg <= SEG_TS1;
          cnt <= '0;
          ext <= '0;
          shr <= '0;
        end else begin
          case (seg)
            SEG_IDLE: ;
            SEG_SYNC: begin
              seg <= SEG_TS1;
              cnt <= '0;
              ext <= '0;
            end
            SEG_TS1: begin
              if (ts1_end) begin
                samp_stb_o <= 1'b1;
                samp_bit_o <= rx_i;
                seg        <= SEG_PH2;
                cnt        <= '0;
                ext        <= '0;
                shr        <= '0;
              end else begin
                cnt <= cnt + CNT_W'(1);
                ext <= ext_n;
              end
            end
            SEG_PH2: begin
              if (full_early) begin
                txpt_o <= 1'b1;
                seg    <= SEG_TS1;
                cnt    <= '0;
                ext    <= '0;
                shr    <= '0;
              end else if (ph2_end) begin
                txpt_o <= 1'b1;
                seg    <= SEG_SYNC;
                cnt    <= '0;
                shr    <= '0;
              end else begin
                cnt <= cnt + CNT_W'(1);
                shr <= shr_n;
              end
            end
            default: seg <= SEG_IDLE;
          endcase
        end
      end
    end
  end

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seg == SEG_IDLE) |-> (!samp_stb_o && !txpt_o));
  // R5
  ext_clip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext <= sjw_x);
  // R6
  shr_clip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shr <= sjw_x);
  // R3
  hard_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tq_i && hard) |=> (seg == SEG_TS1 && cnt == '0 && !samp_stb_o && !txpt_o));
  // R10
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(samp_stb_o && txpt_o));
  // R10
  strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    samp_stb_o |=> !samp_stb_o);
  // R8
  ext_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    samp_stb_o |-> (ext == '0));
endmodule

// File: rtl/canbt_sync.sv
module canbt_sync #(
  parameter int PRESC_W = 8,
  parameter int SEG_W   = 4,
  parameter int SJW_W   = 3,
  localparam int CNT_W  = SEG_W + 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [PRESC_W-1:0] presc_i,
  input  logic [SEG_W-1:0]   prop_len_i,
  input  logic [SEG_W-1:0]   ph1_len_i,
  input  logic [SEG_W-1:0]   ph2_len_i,
  input  logic [SJW_W-1:0]   sjw_i,
  input  logic               hsync_en_i,
  input  logic               rx_i,
  output logic               samp_valid_o,
  output logic               samp_bit_o,
  output logic               txpt_o
);
  logic             tq;
  logic             edge_ok;
  logic             samp_now;
  logic             sync_now;
  logic [CNT_W-1:0] t1;
  logic [CNT_W-1:0] t2;

  assign t1 = CNT_W'(prop_len_i) + CNT_W'(ph1_len_i);
  assign t2 = CNT_W'(ph2_len_i);

  canbt_tq_div #(.PRESC_W(PRESC_W)) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .presc_i (presc_i),
    .tq_o    (tq)
  );

  canbt_edge_det u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .tq_i   (tq),
    .rx_i   (rx_i),
    .samp_i (samp_now),
    .sync_i (sync_now),
    .edge_o (edge_ok)
  );

  canbt_seg_fsm #(.SEG_W(SEG_W), .SJW_W(SJW_W)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .tq_i       (tq),
    .edge_i     (edge_ok),
    .hsync_en_i (hsync_en_i),
    .rx_i       (rx_i),
    .t1_i       (t1),
    .t2_i       (t2),
    .sjw_i      (sjw_i),
    .samp_now_o (samp_now),
    .sync_now_o (sync_now),
    .samp_stb_o (samp_valid_o),
    .samp_bit_o (samp_bit_o),
    .txpt_o     (txpt_o)
  );

  // R5 R6 (configuration legality assumed by the clipping logic)
  cfg_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prop_len_i != '0) && (ph1_len_i != '0) && (ph2_len_i != '0) &&
    (CNT_W'(sjw_i) <= CNT_W'(ph1_len_i)) && (CNT_W'(sjw_i) <= CNT_W'(ph2_len_i)));
endmodule

// File: tb/canbt_sync_bench.sv
`timescale 1ns/1ps
module canbt_sync_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] presc = 8'd0;
  logic [3:0] prop = 4'd1, ph1 = 4'd1, ph2 = 4'd1;
  logic [2:0] sjw = 3'd0;
  logic       hs = 1'b0;
  logic       rx = 1'b1;
  logic       samp_valid, samp_bit, txpt;

  int checks = 0, failures = 0;
  int sc, tc, last_bit;
  logic sbit;
  int T1, T2, NBT, SJ;
  bit done = 0;

  always #2.5 clk = ~clk;

  canbt_sync u_canbt_sync (
    .clk(clk), .rst_n(rst_n), .presc_i(presc), .prop_len_i(prop),
    .ph1_len_i(ph1), .ph2_len_i(ph2), .sjw_i(sjw), .hsync_en_i(hs),
    .rx_i(rx), .samp_valid_o(samp_valid), .samp_bit_o(samp_bit), .txpt_o(txpt)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // one quantum: presc+1 clocks, enable on the last edge
  task automatic step(input logic v, input logic h);
    rx = v; hs = h; sc = 0; tc = 0;
    for (int c = 0; c <= int'(presc); c++) begin
      @(posedge clk); #1;
      if (samp_valid) begin sc++; sbit = samp_bit; end
      if (txpt) tc++;
    end
  endtask

  // runs quanta r=1..es; rx dominant for edge_r<=r<end_r; hsync at hs_r
  task automatic trial(input int edge_r, input int end_r, input int hs_r,
                       input int es, input int et, input int ebit, input string req);
    int ns, nt, os, ot, gb;
    ns = 0; nt = 0; os = 0; ot = 0; gb = -1;
    for (int r = 1; r <= es; r++) begin
      step((edge_r != 0 && r >= edge_r && r < end_r) ? 1'b0 : 1'b1, r == hs_r);
      if (sc > 0) begin ns += sc; if (os == 0) os = r; gb = int'(sbit); end
      if (tc > 0) begin nt += tc; if (ot == 0) ot = r; end
    end
    chk(ns == 1 && os == es, req, "sample quantum", os, es);
    chk(gb == ebit, req, "sampled bit", gb, ebit);
    if (et == 0) chk(nt == 0, req, "no tx strobe", nt, 0);
    else         chk(nt == 1 && ot == et, req, "tx quantum", ot, et);
    last_bit = ebit;
  endtask

  task automatic recover();
    if (last_bit == 0) trial(1, T2 + 2, 0, NBT, T2, 1, "R4 R8");
    else               trial(0, 0, 0, NBT, T2, 1, "R8 R1");
  endtask

  function automatic int imin(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  task automatic run_cfg();
    int e, d, es, r0;
    T1 = int'(prop) + int'(ph1); T2 = int'(ph2); NBT = 1 + T1 + T2; SJ = int'(sjw);
    rst_n = 0; rx = 1; hs = 0;
    repeat (2) @(posedge clk);
    #1;
    chk(!samp_valid && !txpt, "R2", "reset outputs", int'(samp_valid), 0);
    rst_n = 1;
    // R2: idle behaviour before hard sync
    for (int i = 0; i < 3; i++) begin
      step(1'b1, 1'b1);
      chk(sc == 0 && tc == 0, "R2", "idle recessive", sc + tc, 0);
    end
    for (int i = 0; i < 2; i++) begin
      step(1'b0, 1'b0);
      chk(sc == 0 && tc == 0, "R2", "idle dominant no enable", sc + tc, 0);
    end
    // R3: start of frame
    step(1'b0, 1'b1);
    chk(sc == 0 && tc == 0, "R3", "hard sync quantum", sc + tc, 0);
    trial(1, T1 + 1, 0, T1, 0, 0, "R3");
    recover();
    trial(0, 0, 0, NBT, T2, 1, "R1");
    // R5 R7: late edges, line held dominant
    for (int k = 0; k < T1; k++) begin
      trial(T2 + 2 + k, 9999, 0, NBT + imin(k + 1, SJ), T2, 0, "R5 R7");
      recover();
    end
    // R11: edge in sync quantum
    trial(T2 + 1, 9999, 0, NBT, T2, 0, "R11");
    recover();
    // R6: early edges
    for (int k = 0; k < T2; k++) begin
      e = T2 - k; d = imin(e, SJ);
      trial(k + 1, 9999, 0, NBT - d, (d == e) ? k + 1 : T2 - d, 0, "R6");
      recover();
    end
    // R9: spike from first quantum of phase segment 1
    r0 = T2 + 2 + int'(prop);
    es = NBT + imin(int'(prop) + 1, SJ);
    trial(r0, r0 + T1, 0, es, T2, (es < r0 + T1) ? 0 : 1, "R9");
    recover();
    // R3: hard sync mid-bit, late and early
    r0 = T2 + 1 + T1;
    trial(r0, 9999, r0, r0 + T1, T2, 0, "R3");
    recover();
    trial(1, 9999, 1, 1 + T1, 0, 0, "R3");
    recover();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    last_bit = 1;
    foreach (presc_set[i]) ;
    for (int p = 0; p < 2; p++) begin
      for (int pr = 1; pr <= 2; pr++)
        for (int a = 1; a <= 3; a++)
          for (int b = 1; b <= 3; b++)
            for (int s = 0; s <= imin(a, b); s++) begin
              rst_n = 0;
              presc = (p == 0) ? 8'd0 : 8'd2;
              prop = 4'(pr); ph1 = 4'(a); ph2 = 4'(b); sjw = 3'(s);
              run_cfg();
            end
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  int presc_set[1] = '{0};
endmodule